// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that moves one byte per start command and has no queue. A processor reaches it through a small byte-wide register file. Software places a byte in the transmit register and writes the start bit. The block then clocks eight bits out on MOSI and collects eight bits from MISO into the receive register.

Software chooses the clock idle level, the SCK edge on which data is latched and the bit order. An internal loopback can route MOSI into the receive path. The serial clock is the system clock divided by a programmable factor. When the eighth bit completes, a receive-ready flag and an interrupt rise. The busy flag falls one cycle after that. Software reads the receive register, which clears both the flag and the interrupt, and then starts the next byte. Chip-select control belongs to the surrounding system.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads zero, SCK is low, the interrupt is low and status (offset 4) reads 0x00. The reserved offset 5 always reads 0x00.
- R2: A start write (offset 3, bit 0 = 1) is ignored while the port-enable bit of the mode register (offset 0, bit 3) is 0. Busy stays 0, the interrupt stays low and SCK stays idle.
- R3: A start transfers the byte last written to the transmit register (offset 2). It produces exactly eight leading and eight trailing SCK edges. Mode bit 2 selects the order: 0 sends and receives the MSB first, 1 sends and receives the LSB first.
- R4: Mode bit 4 selects the latch edge. When it is 1, MOSI is valid and MISO is sampled on the leading SCK edge, and MOSI changes on trailing edges. When it is 0, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: Mode bit 1 sets the SCK idle level: 0 for low, 1 for high. A leading edge moves SCK away from that level.
- R6: The SCK period is 4*(D+1) system clocks, where D is the 8-bit divisor at offset 6.
- R7: With mode bit 0 set, the receive path samples the block's own MOSI instead of MISO, so the received byte equals the sent byte.
- R8: The receive-ready flag (status bit 0) and the interrupt rise in the cycle after the final SCK edge. Busy (status bit 1) is still 1 in that cycle (status 0x03) and is 0 one cycle later (status 0x01).
- R9: A read of the receive register (offset 1) returns the received byte and clears both the receive-ready flag and the interrupt.
- R10: A start write that arrives while a transfer is in progress is ignored. The current byte completes unchanged and no second transfer follows.
- R11: Between bytes, MOSI holds the last bit sent and SCK rests at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per access |
| reg_re | input | 1 | Read strobe, one cycle per access (side effects only) |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Receive-ready interrupt, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that register strobes last a single cycle and that software does not rewrite the mode or divisor registers while a byte is on the wire. The block latches both at start, and the latched copy is what the edge and timing properties observe. They also assume MISO is stable around the edge that samples it. The bench follows these assumptions. It configures the block only between bytes, changes MISO on the negative clock edge after the SCK edge that the selected phase reserves for changes, and leaves at least one system clock between each SCK edge and the sample that follows it. The single mid-transfer access it makes is the deliberate start-while-busy case.

// File: rtl/spi_byte_pkg.sv
// Shared constants and types for the byte SPI master.
// Assumes a byte-wide register file. The offsets and bit positions here are the
// software contract and must not change.
package spi_byte_pkg;

    localparam int OFS_MODE = 0;
    localparam int OFS_RX   = 1;
    localparam int OFS_TX   = 2;
    localparam int OFS_CTRL = 3;
    localparam int OFS_STAT = 4;
    localparam int OFS_DIV  = 6;

    localparam int MB_LOOP  = 0;
    localparam int MB_CPOL  = 1;
    localparam int MB_LSB   = 2;
    localparam int MB_EN    = 3;
    localparam int MB_LEAD  = 4;

    localparam int CB_GO    = 0;
    localparam int SB_READY = 0;
    localparam int SB_BUSY  = 1;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_TAIL = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic lead;   // 1: latch on leading edge
        logic lsb;    // 1: LSB first
        logic cpol;   // SCK idle level
        logic loopb;  // internal loopback
    } link_cfg_t;

endpackage

// File: rtl/spi_byte_divider.sv
// Quarter-period tick generator.
// Emits one tick every (limit_i+1) clocks while run_i is high, so four ticks
// make one SCK period. The count restarts whenever run_i is low.
module spi_byte_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == limit_i);

    // Count system clocks within one quarter period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: with a nonzero divisor, ticks are never back to back.
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && limit_i != '0) |=> !tick_o);

endmodule

// File: rtl/spi_byte_shifter.sv
// Serial engine: runs one byte through four quarter phases per bit.
// Assumes start_i is a single-cycle request. Configuration and divisor are
// latched when a transfer is accepted. Phases 0-1 keep SCK idle and phases 2-3
// drive it active, so the leading edge opens phase 2.
module spi_byte_shifter
    import spi_byte_pkg::*;
#(
    parameter int BITS  = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             enable_i,
    input  link_cfg_t        cfg_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [BITS-1:0]  tx_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [BITS-1:0]  rx_o
);

    localparam int Q_W = $clog2(BITS * 4);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(BITS * 4 - 1);

    xfer_state_e      state_q;
    logic [Q_W-1:0]   q_q;
    link_cfg_t        cfg_q;
    logic [DIV_W-1:0] div_q;
    logic [BITS-1:0]  tx_sr;
    logic [BITS-1:0]  rx_sr;
    logic             mosi_q;
    logic             tick;
    logic             accept;
    logic             put_now;
    logic             samp_now;
    logic             in_bit;
    logic [1:0]       phase;
    logic [BITS-1:0]  rx_shifted;

    function automatic logic [BITS-1:0] advance(input logic [BITS-1:0] v, input logic lsb);
        return lsb ? {1'b0, v[BITS-1:1]} : {v[BITS-2:0], 1'b0};
    endfunction

    function automatic logic head(input logic [BITS-1:0] v, input logic lsb);
        return lsb ? v[0] : v[BITS-1];
    endfunction

    spi_byte_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == XS_RUN),
        .limit_i (div_q),
        .tick_o  (tick)
    );

    // Decode accept, drive and sample strobes for the current quarter.
    always_comb begin
        phase      = q_q[1:0];
        accept     = start_i && enable_i && (state_q == XS_IDLE);
        put_now    = tick && (cfg_q.lead ? (phase == 2'd3 && q_q != Q_LAST) : (phase == 2'd1));
        samp_now   = tick && (cfg_q.lead ? (phase == 2'd1) : (phase == 2'd3));
        in_bit     = cfg_q.loopb ? mosi_q : miso_i;
        rx_shifted = cfg_q.lsb ? {in_bit, rx_sr[BITS-1:1]} : {rx_sr[BITS-2:0], in_bit};
    end

    // Transfer sequencing, shift registers and the MOSI bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            q_q     <= '0;
            cfg_q   <= '0;
            div_q   <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            mosi_q  <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (accept) begin
                        state_q <= XS_RUN;
                        q_q     <= '0;
                        cfg_q   <= cfg_i;
                        div_q   <= div_i;
                        rx_sr   <= '0;
                        if (cfg_i.lead) begin
                            mosi_q <= head(tx_i, cfg_i.lsb);
                            tx_sr  <= advance(tx_i, cfg_i.lsb);
                        end else begin
                            tx_sr  <= tx_i;
                        end
                    end
                end
                XS_RUN: begin
                    if (tick) begin
                        q_q <= q_q + 1'b1;
                        if (put_now) begin
                            mosi_q <= head(tx_sr, cfg_q.lsb);
                            tx_sr  <= advance(tx_sr, cfg_q.lsb);
                        end
                        if (samp_now) begin
                            rx_sr <= rx_shifted;
                        end
                        if (q_q == Q_LAST) begin
                            state_q <= XS_TAIL;
                        end
                    end
                end
                XS_TAIL: state_q <= XS_IDLE;
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign sck_o  = (state_q == XS_IDLE) ? cfg_i.cpol : (cfg_q.cpol ^ q_q[1]);
    assign mosi_o = mosi_q;
    assign busy_o = (state_q != XS_IDLE);
    assign done_o = (state_q == XS_RUN) && tick && (q_q == Q_LAST);
    assign rx_o   = samp_now ? rx_shifted : rx_sr;

    // R8: busy holds exactly one cycle past done.
    a_r8_tail_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (busy_o && !done_o));
    a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(done_o)) |=> !busy_o);

    // R2: a start with the port disabled leaves the engine idle.
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE && start_i && !enable_i) |=> !busy_o);

    // R10: a start during a transfer never rewinds the phase counter.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_RUN && start_i && !done_o) |=>
        (q_q == $past(q_q) || q_q == $past(q_q) + 1'b1));

    // R11: outside a running transfer MOSI keeps its last bit.
    a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != XS_RUN && !accept) |=> $stable(mosi_o));

endmodule

// File: rtl/spi_byte_regs.sv
// Byte-wide register file: mode, receive, transmit, start, status, divisor.
// Assumes single-cycle strobes. Read data is combinational and the receive
// read side effect lands on the strobe's clock edge. Completion beats a
// simultaneous clearing read.
module spi_byte_regs
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] rx_i,
    output link_cfg_t         cfg_o,
    output logic              enable_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [BYTE_W-1:0] tx_o,
    output logic              start_o,
    output logic              irq_o
);

    logic [BYTE_W-1:0] mode_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [DIV_W-1:0]  div_q;
    logic              ready_q;
    logic              rx_read;

    assign rx_read = re_i && (addr_i == ADDR_W'(OFS_RX));

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tx_q   <= '0;
            div_q  <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADDR_W'(OFS_MODE): mode_q <= wdata_i;
                ADDR_W'(OFS_TX):   tx_q   <= wdata_i;
                ADDR_W'(OFS_DIV):  div_q  <= DIV_W'(wdata_i);
                default: ;
            endcase
        end
    end

    // Receive byte and ready flag: set on completion, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            ready_q <= 1'b0;
        end else if (done_i) begin
            rx_q    <= rx_i;
            ready_q <= 1'b1;
        end else if (rx_read) begin
            ready_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFS_MODE): rdata_o = mode_q;
            ADDR_W'(OFS_RX):   rdata_o = rx_q;
            ADDR_W'(OFS_TX):   rdata_o = tx_q;
            ADDR_W'(OFS_STAT): begin
                rdata_o[SB_READY] = ready_q;
                rdata_o[SB_BUSY]  = busy_i;
            end
            ADDR_W'(OFS_DIV):  rdata_o = BYTE_W'(div_q);
            default:           rdata_o = '0;
        endcase
    end

    assign cfg_o    = '{lead: mode_q[MB_LEAD], lsb: mode_q[MB_LSB],
                        cpol: mode_q[MB_CPOL], loopb: mode_q[MB_LOOP]};
    assign enable_o = mode_q[MB_EN];
    assign div_o    = div_q;
    assign tx_o     = tx_q;
    assign start_o  = we_i && (addr_i == ADDR_W'(OFS_CTRL)) && wdata_i[CB_GO];
    assign irq_o    = ready_q;

    // R9: reading the receive byte drops the interrupt unless a byte lands then.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !done_i) |=> !irq_o);

    // R8: completion always raises the interrupt on the next cycle.
    a_r8_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> irq_o);

endmodule

// File: rtl/spi_byte_master.sv
// Top level: register file plus serial engine for single-byte SPI transfers.
// Assumes software leaves mode and divisor unchanged while busy. Chip select
// is handled outside this block.
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);

    link_cfg_t         cfg;
    logic              enable;
    logic [DIV_W-1:0]  div;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
    logic              start;
    logic              busy;
    logic              done;

    spi_byte_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .we_i     (reg_we),
        .re_i     (reg_re),
        .rdata_o  (reg_rdata),
        .busy_i   (busy),
        .done_i   (done),
        .rx_i     (rx_byte),
        .cfg_o    (cfg),
        .enable_o (enable),
        .div_o    (div),
        .tx_o     (tx_byte),
        .start_o  (start),
        .irq_o    (irq)
    );

    spi_byte_shifter #(.BITS(BYTE_W), .DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .enable_i (enable),
        .cfg_i    (cfg),
        .div_i    (div),
        .tx_i     (tx_byte),
        .miso_i   (miso),
        .sck_o    (sck),
        .mosi_o   (mosi),
        .busy_o   (busy),
        .done_o   (done),
        .rx_o     (rx_byte)
    );

endmodule

// File: tb/tb_spi_byte_master.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_spi_byte_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq, sck, mosi;
    logic       miso = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    spi_byte_master dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit consume, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = consume;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    task automatic test_reset();
        logic [7:0] v;
        chk("R1 sck after reset", sck, 0);
        chk("R1 irq after reset", irq, 0);
        rd(3'd0, 0, v); chk("R1 mode reg", v, 0);
        rd(3'd2, 0, v); chk("R1 tx reg", v, 0);
        rd(3'd6, 0, v); chk("R1 divisor reg", v, 0);
        rd(3'd4, 0, v); chk("R1 status reg", v, 0);
        rd(3'd1, 0, v); chk("R1 rx reg", v, 0);
        rd(3'd5, 0, v); chk("R1 reserved reg", v, 0);
    endtask

    task automatic test_disabled();
        logic [7:0] v;
        wr(3'd0, 8'h10);
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'h01);
        repeat (30) @(negedge clk);
        chk("R2 irq with port disabled", irq, 0);
        chk("R2 sck idle with port disabled", sck, 0);
        rd(3'd4, 0, v); chk("R2 status with port disabled", v, 0);
    endtask

    task automatic run_case(input string tag, input logic [7:0] mode, input logic [7:0] cdm,
                            input logic [7:0] txb, input logic [7:0] misob,
                            input logic [7:0] exp_rx, input bit poke);
        logic       lead = mode[4];
        logic       lsb  = mode[2];
        logic       cpol = mode[1];
        logic [7:0] seen = '0;
        logic [7:0] v;
        logic       prev;
        int         nl = 0, nt = 0, cyc = 0, c0 = 0, c1 = 0, pk = 0;
        bit         hung = 0;
        wr(3'd6, cdm);
        wr(3'd0, mode);
        wr(3'd2, txb);
        miso = lead ? bitof(misob, 0, lsb) : 1'b0;
        @(negedge clk);
        reg_addr = 3'd3; reg_wdata = 8'h01; reg_we = 1'b1;
        prev = cpol;
        forever begin
            @(negedge clk);
            cyc++;
            reg_we = 1'b0;
            if (pk == 1) begin
                reg_addr = 3'd2; reg_wdata = ~txb; reg_we = 1'b1; pk = 2;
            end else if (pk == 2) begin
                reg_addr = 3'd3; reg_wdata = 8'h01; reg_we = 1'b1; pk = 3;
            end
            if (sck !== prev) begin
                if (sck != cpol) begin
                    if (nl == 0) c0 = cyc;
                    if (nl == 1) c1 = cyc;
                    if (nl < 8) begin
                        if (lead) seen[lsb ? nl : 7 - nl] = mosi;
                        else miso = bitof(misob, nl, lsb);
                    end
                    nl++;
                    if (poke && nl == 3 && pk == 0) pk = 1;
                end else begin
                    if (!lead && nt < 8) seen[lsb ? nt : 7 - nt] = mosi;
                    nt++;
                    if (lead && nt < 8) miso = bitof(misob, nt, lsb);
                end
                prev = sck;
            end
            if (irq) break;
            if (cyc > 4000) begin hung = 1; break; end
        end
        reg_we = 1'b0;
        chk({tag, " R8 transfer completes"}, hung, 0);
        reg_addr = 3'd4;
        #1 chk({tag, " R8 status on ready cycle"}, reg_rdata, 8'h03);
        @(negedge clk);
        #1 chk({tag, " R8 status one cycle later"}, reg_rdata, 8'h01);
        chk({tag, " R3 leading edges"}, nl, 8);
        chk({tag, " R3 trailing edges"}, nt, 8);
        chk({tag, " R4 MOSI byte at latch edges"}, seen, txb);
        chk({tag, " R6 SCK period"}, c1 - c0, 4 * (cdm + 1));
        chk({tag, " R5 SCK idle level after byte"}, sck, cpol);
        chk({tag, " R11 MOSI holds last bit"}, mosi, bitof(txb, 7, lsb));
        rd(3'd1, 1, v);
        chk({tag, " R3 received byte"}, v, exp_rx);
        chk({tag, " R9 irq cleared by rx read"}, irq, 0);
        rd(3'd4, 0, v);
        chk({tag, " R9 status after rx read"}, v, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            chk({tag, " R10 no second transfer irq"}, irq, 0);
            rd(3'd4, 0, v);
            chk({tag, " R10 no second transfer status"}, v, 0);
            chk({tag, " R10 SCK idle"}, sck, cpol);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_disabled();
        run_case("lead-latch cpol0 msb", 8'h18, 8'd0, 8'hA5, 8'h3C, 8'h3C, 0);
        run_case("trail-latch cpol0 msb", 8'h08, 8'd2, 8'h96, 8'h5A, 8'h5A, 0);
        run_case("lead-latch cpol1 lsb", 8'h1E, 8'd1, 8'h81, 8'h4E, 8'h4E, 0);
        run_case("trail-latch cpol1 lsb", 8'h0E, 8'd0, 8'h37, 8'hC1, 8'hC1, 0);
        run_case("R7 loopback", 8'h19, 8'd1, 8'h6B, 8'h94, 8'h6B, 0);
        run_case("R10 start while busy", 8'h18, 8'd3, 8'hC3, 8'h0F, 8'h0F, 1);
        finish_run();
    end

endmodule